// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes two-channel serial audio made of a bit clock, a channel-select line and one data line, and turns each left/right pair into two parallel 24-bit words. A valid strobe in the system-clock domain marks every new pair. A two-bit format code picks the framing. One code selects the standard inter-IC sound layout, where the word starts one bit clock after the channel-select change. The other three select a right-aligned layout, where the word of 16, 20 or 24 bits ends exactly on the last bit before channel select changes.

Framing, shifting and word alignment all run on the bit clock. Channel select and data are sampled on its rising edge. A completed pair is parked in holding registers, and a toggle flag is passed to the system clock through a short synchronizer chain. The system side then copies the pair to its outputs and pulses valid for one cycle. In right-aligned modes, a slot that carries fewer bits than the selected width sets an error flag that travels with the pair.

Top module: `stereo_serial_rx`

## Requirements
- R1: With format code 00, the first data bit after a channel-select change is one bit clock later, MSB first; channel select low is the left channel, high the right channel.
- R2: With format code 00, the first up to 24 bits of a slot form the word, left-aligned in the 24-bit output; a shorter word is padded with zeros below its LSB, and slot bits after the 24th are dropped.
- R3: With format code 01, the last 16 bits of each slot appear in output bits 23..8, output bits 7..0 are zero, and earlier slot bits are discarded.
- R4: With format code 10, the last 20 bits of each slot appear in output bits 23..4, output bits 3..0 are zero, and earlier slot bits are discarded.
- R5: With format code 11, the last 24 bits of each slot appear in output bits 23..0, and earlier slot bits are discarded.
- R6: valid_o is high for exactly one system clock per completed left/right pair, only after the right word has ended; left_o, right_o and err_o change only in the cycle valid_o is high.
- R7: In right-aligned modes err_o is high with a pair when either of its slots held fewer bits than the selected width, and low with a pair whose slots were long enough.
- R8: After reset the outputs are zero and valid_o is low; the slot in progress at reset release, and a right word with no left word before it, produce no pair.
- R9: With format code 00, err_o is never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the output side |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| bclk | input | 1 | Serial bit clock |
| ws | input | 1 | Channel select, changes on falling bclk |
| sdata | input | 1 | Serial data, MSB first |
| fmt | input | 2 | Framing code: 00 standard, 01/10/11 right-aligned 16/20/24 |
| left_o | output | 24 | Left word, left-aligned |
| right_o | output | 24 | Right word, left-aligned |
| valid_o | output | 1 | One-cycle pulse per new pair |
| err_o | output | 1 | Short-slot flag for the pair shown |

## Verification
The short-slot error and the pair handoff land in the same system cycle, because err_o is updated only together with the new words. The bench provokes this with 16-bit slots while the 24-bit right-aligned code is selected. It expects err_o high in the very cycle valid_o pulses, with the short words still delivered zero-filled. The next pair uses full slots, and the bench requires err_o to drop in that pair's valid cycle.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [1:0] {
        FMT_STD  = 2'b00,
        FMT_RA16 = 2'b01,
        FMT_RA20 = 2'b10,
        FMT_RA24 = 2'b11
    } fmt_e;

    function automatic int unsigned ra_width(fmt_e f);
        case (f)
            FMT_RA16: return 16;
            FMT_RA20: return 20;
            default:  return 24;
        endcase
    endfunction

endpackage

// File: rtl/rx_slot_shift.sv
module rx_slot_shift
    import rx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                ws,
    input  logic                sd,
    input  fmt_e                fmt,
    output logic                word_stb,
    output logic                word_right,
    output logic [SAMPLE_W-1:0] word_data,
    output logic                word_short
);

    localparam int CNT_W = $clog2(SLOT_W + 1);

    typedef struct packed {
        fmt_e                fmt_m;
        fmt_e                fmt_s;
        logic                primed;
        logic                locked;
        logic                ws_prev;
        logic [SLOT_W-1:0]   shreg;
        logic [CNT_W-1:0]    cnt;
        logic                stb;
        logic                right;
        logic [SAMPLE_W-1:0] data;
        logic                short_w;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        int unsigned       need;
        int unsigned       nbits;
        logic [SLOT_W-1:0] win;
        logic [SLOT_W-1:0] tmp;
        logic [SLOT_W-1:0] keep;
        logic              slot_edge;

        s_d          = s_q;
        s_d.stb      = 1'b0;
        s_d.fmt_m    = fmt;
        s_d.fmt_s    = s_q.fmt_m;
        s_d.primed   = 1'b1;
        s_d.ws_prev  = ws;
        need         = ra_width(s_q.fmt_s);
        win          = {s_q.shreg[SLOT_W-2:0], sd};
        nbits        = 32'(s_q.cnt) + 32'd1;
        tmp          = '0;
        keep         = '0;
        slot_edge    = s_q.primed && (ws != s_q.ws_prev);

        if (slot_edge) begin
            s_d.locked = 1'b1;
            s_d.stb    = s_q.locked;
            s_d.right  = s_q.ws_prev;
            if (s_q.fmt_s == FMT_STD) begin
                // the bit sampled now is still the tail of the old slot
                if (nbits >= 32'(SAMPLE_W)) tmp = win >> (nbits - 32'(SAMPLE_W));
                else                        tmp = win << (32'(SAMPLE_W) - nbits);
                s_d.data    = tmp[SAMPLE_W-1:0];
                s_d.short_w = 1'b0;
                s_d.shreg   = '0;
                s_d.cnt     = '0;
            end else begin
                // the bit sampled now already opens the new slot
                keep        = s_q.shreg & ~({SLOT_W{1'b1}} << need);
                tmp         = keep << (32'(SAMPLE_W) - need);
                s_d.data    = tmp[SAMPLE_W-1:0];
                s_d.short_w = (32'(s_q.cnt) < need);
                s_d.shreg   = {{(SLOT_W-1){1'b0}}, sd};
                s_d.cnt     = CNT_W'(1);
            end
        end else begin
            s_d.shreg = win;
            if (32'(s_q.cnt) < 32'(SLOT_W)) s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_stb   = s_q.stb;
    assign word_right = s_q.right;
    assign word_data  = s_q.data;
    assign word_short = s_q.short_w;

endmodule

// File: rtl/rx_pair_hold.sv
module rx_pair_hold #(
    parameter int SAMPLE_W = 24
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                word_stb,
    input  logic                word_right,
    input  logic [SAMPLE_W-1:0] word_data,
    input  logic                word_short,
    output logic [SAMPLE_W-1:0] hold_l,
    output logic [SAMPLE_W-1:0] hold_r,
    output logic                hold_err,
    output logic                pair_tgl
);

    typedef struct packed {
        logic                have_l;
        logic [SAMPLE_W-1:0] tmp_l;
        logic                tmp_err;
        logic [SAMPLE_W-1:0] out_l;
        logic [SAMPLE_W-1:0] out_r;
        logic                out_err;
        logic                tgl;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (word_stb) begin
            if (!word_right) begin
                s_d.have_l  = 1'b1;
                s_d.tmp_l   = word_data;
                s_d.tmp_err = word_short;
            end else if (s_q.have_l) begin
                s_d.have_l  = 1'b0;
                s_d.out_l   = s_q.tmp_l;
                s_d.out_r   = word_data;
                s_d.out_err = s_q.tmp_err | word_short;
                s_d.tgl     = ~s_q.tgl;
            end
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hold_l   = s_q.out_l;
    assign hold_r   = s_q.out_r;
    assign hold_err = s_q.out_err;
    assign pair_tgl = s_q.tgl;

endmodule

// File: rtl/rx_sys_handoff.sv
module rx_sys_handoff #(
    parameter int SAMPLE_W = 24,
    parameter int SYNC_N   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pair_tgl,
    input  logic [SAMPLE_W-1:0] hold_l,
    input  logic [SAMPLE_W-1:0] hold_r,
    input  logic                hold_err,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                err_o
);

    typedef struct packed {
        logic [SYNC_N-1:0]   sync;
        logic                seen;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                err;
        logic                valid;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        logic arrived;
        s_d       = s_q;
        s_d.sync  = {s_q.sync[SYNC_N-2:0], pair_tgl};
        s_d.seen  = s_q.sync[SYNC_N-1];
        arrived   = s_q.sync[SYNC_N-1] ^ s_q.seen;
        s_d.valid = arrived;
        if (arrived) begin
            // holding registers are quiet for many bit clocks after a toggle
            s_d.left  = hold_l;
            s_d.right = hold_r;
            s_d.err   = hold_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign left_o  = s_q.left;
    assign right_o = s_q.right;
    assign valid_o = s_q.valid;
    assign err_o   = s_q.err;

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
    import rx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32,
    parameter int SYNC_N   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                ws,
    input  logic                sdata,
    input  logic [1:0]          fmt,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                err_o
);

    logic                word_stb;
    logic                word_right;
    logic [SAMPLE_W-1:0] word_data;
    logic                word_short;
    logic [SAMPLE_W-1:0] hold_l;
    logic [SAMPLE_W-1:0] hold_r;
    logic                hold_err;
    logic                pair_tgl;

    rx_slot_shift #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_shift (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .ws         (ws),
        .sd         (sdata),
        .fmt        (fmt_e'(fmt)),
        .word_stb   (word_stb),
        .word_right (word_right),
        .word_data  (word_data),
        .word_short (word_short)
    );

    rx_pair_hold #(.SAMPLE_W(SAMPLE_W)) u_pair (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .word_stb   (word_stb),
        .word_right (word_right),
        .word_data  (word_data),
        .word_short (word_short),
        .hold_l     (hold_l),
        .hold_r     (hold_r),
        .hold_err   (hold_err),
        .pair_tgl   (pair_tgl)
    );

    rx_sys_handoff #(.SAMPLE_W(SAMPLE_W), .SYNC_N(SYNC_N)) u_hand (
        .clk      (clk),
        .rst_n    (rst_n),
        .pair_tgl (pair_tgl),
        .hold_l   (hold_l),
        .hold_r   (hold_r),
        .hold_err (hold_err),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (valid_o),
        .err_o    (err_o)
    );

endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          fmt,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                valid_o,
    input logic                err_o
);

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o) && $stable(err_o))); // R6

    AST_ERR_WITH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> valid_o); // R7

    AST_STD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fmt == 2'b00) |-> !err_o); // R9

    AST_RA16_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fmt == 2'b01) |-> (left_o[7:0] == 8'd0 && right_o[7:0] == 8'd0)); // R3

    AST_RA20_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fmt == 2'b10) |-> (left_o[3:0] == 4'd0 && right_o[3:0] == 4'd0)); // R4

endmodule

bind stereo_serial_rx rx_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt     (fmt),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o),
    .err_o   (err_o)
);

// File: tb/sim_stereo_serial_rx.sv
module sim_stereo_serial_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        ws = 1'b1;
    logic        sdata = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        valid_o;
    logic        err_o;

    int checks = 0;
    int fails  = 0;
    logic carry = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
        logic        e;
        string       tag;
    } pair_t;

    pair_t exp_q[$];

    always #2 clk = ~clk;

    stereo_serial_rx u0 (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .ws(ws), .sdata(sdata),
        .fmt(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .err_o(err_o)
    );

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            pair_t p;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R8/R6 unexpected pair: got l=%h r=%h exp none", left_o, right_o);
            end else begin
                p = exp_q.pop_front();
                if (left_o !== p.l || right_o !== p.r || err_o !== p.e) begin
                    fails++;
                    $display("FAIL %s got l=%h r=%h e=%b exp l=%h r=%h e=%b",
                             p.tag, left_o, right_o, err_o, p.l, p.r, p.e);
                end
            end
        end
    end

    task automatic push_bit(input logic w, input logic d);
        ws = w;
        sdata = d;
        #20 bclk = 1'b1;
        #20 bclk = 1'b0;
    endtask

    // standard framing: data delayed one bit after the channel-select change
    task automatic std_slot(input logic w, input logic [31:0] word, input int wlen, input int slen);
        push_bit(w, carry);
        for (int p = 0; p < slen - 1; p++)
            push_bit(w, (p < wlen) ? word[wlen-1-p] : 1'b0);
        carry = (slen - 1 < wlen) ? word[wlen-slen] : 1'b0;
    endtask

    function automatic logic [23:0] std_exp(input logic [31:0] word, input int wlen);
        logic [31:0] t;
        t = word << (24 - wlen);
        return t[23:0];
    endfunction

    task automatic std_pair(input logic [31:0] l, input logic [31:0] r, input int wlen,
                            input int slen, input string tag);
        pair_t p;
        p.l = std_exp(l, wlen); p.r = std_exp(r, wlen); p.e = 1'b0; p.tag = tag;
        exp_q.push_back(p);
        std_slot(1'b0, l, wlen, slen);
        std_slot(1'b1, r, wlen, slen);
    endtask

    // right-aligned framing: junk ones ahead of the word
    task automatic ra_slot(input logic w, input logic [31:0] word, input int n, input int slen);
        for (int t = 0; t < slen; t++)
            push_bit(w, (t >= slen - n) ? word[slen-1-t] : 1'b1);
    endtask

    function automatic logic [23:0] ra_exp(input logic [31:0] word, input int n, input int slen);
        int keep;
        logic [31:0] v;
        keep = (slen < n) ? slen : n;
        v = word & ((32'd1 << keep) - 32'd1);
        v = v << (24 - n);
        return v[23:0];
    endfunction

    task automatic ra_pair(input logic [31:0] l, input logic [31:0] r, input int n,
                           input int slen, input string tag);
        pair_t p;
        p.l = ra_exp(l, n, slen); p.r = ra_exp(r, n, slen); p.e = (slen < n); p.tag = tag;
        exp_q.push_back(p);
        ra_slot(1'b0, l, n, slen);
        ra_slot(1'b1, r, n, slen);
    endtask

    task automatic begin_group(input logic [1:0] f, input bit lead);
        rst_n = 1'b0; fmt = f; ws = 1'b1; sdata = 1'b0; bclk = 1'b0; carry = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        checks++;
        if (valid_o !== 1'b0 || left_o !== 24'd0 || right_o !== 24'd0 || err_o !== 1'b0) begin
            fails++;
            $display("FAIL R8 reset state got v=%b l=%h r=%h e=%b exp all zero",
                     valid_o, left_o, right_o, err_o);
        end
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        if (lead) for (int i = 0; i < 4; i++) push_bit(1'b1, 1'b0);
    endtask

    task automatic end_group(input string tag);
        push_bit(1'b0, carry);
        push_bit(1'b0, 1'b0);
        push_bit(1'b0, 1'b0);
        repeat (40) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s pairs missing got %0d left over exp 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired got hang exp completion");
        summary();
    end

    initial begin
        // R1 R2 R9: standard framing, assorted word and slot lengths
        begin_group(2'b00, 1'b1);
        std_pair(32'h00A5C3E1, 32'h005A3C1E, 24, 32, "R1");
        std_pair(32'h0000BEEF, 32'h00001234, 16, 32, "R2");
        std_pair(32'h00800001, 32'h007FFFFE, 24, 24, "R1");
        std_pair(32'h0000F00D, 32'h00008001, 16, 16, "R2");
        std_pair(32'h000ABCDE, 32'h00054321, 20, 32, "R9");
        end_group("R6");

        // R3 R8: partial left slot and orphan right slot yield nothing
        begin_group(2'b01, 1'b0);
        for (int i = 0; i < 5; i++) push_bit(1'b0, 1'b1);
        ra_slot(1'b1, 32'h0000DEAD, 16, 32);
        ra_pair(32'h0000CAFE, 32'h00001357, 16, 32, "R3");
        ra_pair(32'h00008421, 32'h0000FFFF, 16, 16, "R3");
        end_group("R8");

        // R4
        begin_group(2'b10, 1'b1);
        ra_pair(32'h000F1E2D, 32'h00080001, 20, 32, "R4");
        ra_pair(32'h000A5A5A, 32'h00055555, 20, 24, "R4");
        end_group("R6");

        // R5 R7: full slots, short slots flag the error, recovery afterwards
        begin_group(2'b11, 1'b1);
        ra_pair(32'h00C0FFEE, 32'h00123456, 24, 32, "R5");
        ra_pair(32'h00800000, 32'h007FFFFF, 24, 24, "R5");
        ra_pair(32'h0000ABCD, 32'h00004321, 24, 16, "R7");
        ra_pair(32'h00FEDCBA, 32'h00010203, 24, 32, "R7");
        end_group("R6");

        summary();
    end

endmodule